// File: doc/BRIEF.md
# Multi-Function Control Input Manager

This block turns one external general-purpose control pin into the power and output controls of a three-PLL clock generator. A two-bit configuration field, fixed at configuration time, gives the pin one of four roles: frequency select, suspend, output enable or full shutdown. The pin passes through a two-flop synchronizer and a one-cycle stability filter before any role acts on it. The filtered level then drives registered outputs: a drive enable per clock output, a run enable per PLL, an oscillator enable and a frequency-select level.

In suspend, a programmed PLL mask and a programmed output mask apply while the pin is low. The block checks these masks against the per-output source routing. Any output fed by a suspended PLL is forced into suspend, and a configuration-error flag is raised.

When shutdown is released, the oscillator and PLLs restart but the outputs stay undriven. They return when all PLLs report lock. If lock does not arrive within a programmable wait, the outputs return anyway and a sticky lock-error flag is set.

Top module: `cim_ctrl_pin_mgr`

## Requirements
- R1: The role field encodes 0 = frequency select, 1 = suspend, 2 = output enable, 3 = shutdown. In the frequency-select role, `fsel_o` follows the filtered pin level, and every output, PLL and oscillator enable stays high.
- R2: A pin level held steady is reflected on the registered outputs no more than 6 control-clock cycles after it is first applied.
- R3: A pin pulse lasting a single control-clock cycle has no effect on any output.
- R4: In the output-enable role with the pin low, all output enables are 0 while all PLL run enables and the oscillator enable stay 1.
- R5: In the suspend role with the pin low, `pll_run_o` equals the inverse of the PLL suspend mask and `out_en_o` equals the inverse of the effective output suspend mask. The oscillator stays enabled.
- R6: Output n takes its source code from bits [2n+1:2n] of `cfg_src_i`: code 0 is the reference and code k (1..3) is PLL k-1. An output whose source PLL is in the PLL suspend mask is suspended even if its own mask bit is clear. `cfg_err_o` is 1 exactly when such a forced output exists. An output fed from the reference is never forced.
- R7: In the shutdown role with the pin low, all output, PLL and oscillator enables are 0.
- R8: After shutdown is released, the oscillator and all PLLs are enabled while every output enable stays 0. This holds until all bits of `pll_lock_i` are 1, after which all outputs return.
- R9: If lock is not seen within LOCK_WAIT cycles of release, the outputs return and `lock_err_o` goes to 1. It stays 1 until reset.
- R10: `fsel_o` is 0 whenever the role is not frequency select.
- R11: During reset, all enables are 1 and `fsel_o`, `cfg_err_o` and `lock_err_o` are 0.
- R12: In the suspend and output-enable roles with the pin high, all enables are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 1 | Asynchronous general-purpose control pin |
| cfg_role_i | input | 2 | Pin role code |
| cfg_pll_mask_i | input | NUM_PLL | PLLs stopped in suspend |
| cfg_out_mask_i | input | NUM_OUT | Outputs undriven in suspend |
| cfg_src_i | input | NUM_OUT*SRC_W | Per-output source code |
| pll_lock_i | input | NUM_PLL | Lock indication per PLL |
| out_en_o | output | NUM_OUT | Output drive enable (0 = three-state) |
| pll_run_o | output | NUM_PLL | PLL run enable |
| osc_en_o | output | 1 | Reference oscillator enable |
| fsel_o | output | 1 | Frequency-select level |
| cfg_err_o | output | 1 | Suspend mask breaks the routing rule |
| lock_err_o | output | 1 | Sticky lock-wait expiry |

## Verification
The bench programs a suspend mask that leaves one PLL-fed output unmasked. A design without the routing check would keep that output driven from a stopped PLL and leave the error flag low. An output fed from the reference is placed next to a suspended PLL, to catch a design that forces outputs by mistake. A single-cycle pin pulse is applied: a design without the stability filter would toggle the select level. The shutdown exit is run twice, once with lock arriving late and once with lock never arriving. These runs expose a design that drives outputs before lock, one that waits forever, and one whose lock-error flag fails to stick.

// File: rtl/cim_pkg.sv
package cim_pkg;
  typedef enum logic [1:0] {
    ROLE_FSEL = 2'd0,
    ROLE_SUSP = 2'd1,
    ROLE_OE   = 2'd2,
    ROLE_SHUT = 2'd3
  } role_e;

  typedef enum logic [1:0] {
    PW_RUN    = 2'd0,
    PW_OFF    = 2'd1,
    PW_RELOCK = 2'd2
  } pwr_e;
endpackage

// File: rtl/cim_pin_filter.sv
module cim_pin_filter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic lvl_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      prev_q <= 1'b1;
      lvl_o  <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      prev_q <= sync_q[SYNC_STAGES-1];
      if (prev_q == sync_q[SYNC_STAGES-1])
        lvl_o <= prev_q;
    end
  end
endmodule

// File: rtl/cim_route_check.sv
module cim_route_check #(
  parameter int NUM_PLL = 3,
  parameter int NUM_OUT = 3,
  parameter int SRC_W   = 2
) (
  input  logic [NUM_PLL-1:0]       pll_mask_i,
  input  logic [NUM_OUT-1:0]       out_mask_i,
  input  logic [NUM_OUT*SRC_W-1:0] src_i,
  output logic [NUM_OUT-1:0]       eff_mask_o,
  output logic                     err_o
);
  logic [NUM_OUT-1:0] forced;

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    logic [SRC_W-1:0] code;
    assign code = src_i[o*SRC_W +: SRC_W];
    always_comb begin
      forced[o] = 1'b0;
      for (int p = 0; p < NUM_PLL; p++)
        if (code == SRC_W'(p + 1) && pll_mask_i[p])
          forced[o] = 1'b1;
    end
  end

  assign eff_mask_o = out_mask_i | forced;
  assign err_o      = |(forced & ~out_mask_i);
endmodule

// File: rtl/cim_relock_fsm.sv
module cim_relock_fsm
  import cim_pkg::*;
#(
  parameter int LOCK_WAIT = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic shut_req_i,
  input  logic lock_all_i,
  output pwr_e state_o,
  output logic lock_err_o
);
  localparam int CNT_W = $clog2(LOCK_WAIT + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_o    <= PW_RUN;
      cnt_q      <= '0;
      lock_err_o <= 1'b0;
    end else begin
      unique case (state_o)
        PW_RUN: if (shut_req_i) state_o <= PW_OFF;
        PW_OFF: if (!shut_req_i) begin
          state_o <= PW_RELOCK;
          cnt_q   <= '0;
        end
        PW_RELOCK: begin
          if (shut_req_i) begin
            state_o <= PW_OFF;
          end else if (lock_all_i) begin
            state_o <= PW_RUN;
          end else if (cnt_q == CNT_W'(LOCK_WAIT - 1)) begin
            state_o    <= PW_RUN;
            lock_err_o <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_o <= PW_RUN;
      endcase
    end
  end
endmodule

// File: rtl/cim_ctrl_pin_mgr.sv
module cim_ctrl_pin_mgr
  import cim_pkg::*;
#(
  parameter int NUM_PLL     = 3,
  parameter int NUM_OUT     = 3,
  parameter int SYNC_STAGES = 2,
  parameter int LOCK_WAIT   = 4096,
  localparam int SRC_W      = $clog2(NUM_PLL + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     pin_i,
  input  logic [1:0]               cfg_role_i,
  input  logic [NUM_PLL-1:0]       cfg_pll_mask_i,
  input  logic [NUM_OUT-1:0]       cfg_out_mask_i,
  input  logic [NUM_OUT*SRC_W-1:0] cfg_src_i,
  input  logic [NUM_PLL-1:0]       pll_lock_i,
  output logic [NUM_OUT-1:0]       out_en_o,
  output logic [NUM_PLL-1:0]       pll_run_o,
  output logic                     osc_en_o,
  output logic                     fsel_o,
  output logic                     cfg_err_o,
  output logic                     lock_err_o
);
  role_e              role;
  logic               lvl;
  logic [NUM_OUT-1:0] eff_mask;
  logic               route_err;
  pwr_e               pst;
  logic               shut_req;
  logic [NUM_OUT-1:0] n_out;
  logic [NUM_PLL-1:0] n_run;
  logic               n_osc;
  logic               n_fsel;

  assign role     = role_e'(cfg_role_i);
  assign shut_req = (role == ROLE_SHUT) && !lvl;

  cim_pin_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filt (
    .clk(clk), .rst(rst), .pin_i(pin_i), .lvl_o(lvl)
  );

  cim_route_check #(.NUM_PLL(NUM_PLL), .NUM_OUT(NUM_OUT), .SRC_W(SRC_W)) u_route (
    .pll_mask_i(cfg_pll_mask_i), .out_mask_i(cfg_out_mask_i), .src_i(cfg_src_i),
    .eff_mask_o(eff_mask), .err_o(route_err)
  );

  cim_relock_fsm #(.LOCK_WAIT(LOCK_WAIT)) u_fsm (
    .clk(clk), .rst(rst), .shut_req_i(shut_req), .lock_all_i(&pll_lock_i),
    .state_o(pst), .lock_err_o(lock_err_o)
  );

  always_comb begin
    n_out  = '1;
    n_run  = '1;
    n_osc  = 1'b1;
    n_fsel = 1'b0;
    unique case (role)
      ROLE_FSEL: n_fsel = lvl;
      ROLE_SUSP: if (!lvl) begin
        n_run = ~cfg_pll_mask_i;
        n_out = ~eff_mask;
      end
      ROLE_OE:   if (!lvl) n_out = '0;
      default:   ;
    endcase
    if (pst == PW_OFF) begin
      n_out = '0;
      n_run = '0;
      n_osc = 1'b0;
    end else if (pst == PW_RELOCK) begin
      n_out = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_en_o  <= '1;
      pll_run_o <= '1;
      osc_en_o  <= 1'b1;
      fsel_o    <= 1'b0;
      cfg_err_o <= 1'b0;
    end else begin
      out_en_o  <= n_out;
      pll_run_o <= n_run;
      osc_en_o  <= n_osc;
      fsel_o    <= n_fsel;
      cfg_err_o <= route_err;
    end
  end
endmodule

// File: rtl/cim_ctrl_pin_mgr_chk.sv
module cim_ctrl_pin_mgr_chk #(
  parameter int NUM_PLL = 3,
  parameter int NUM_OUT = 3,
  parameter int SRC_W   = 2
) (
  input logic                     clk,
  input logic                     rst,
  input logic [1:0]               cfg_role_i,
  input logic [NUM_OUT*SRC_W-1:0] cfg_src_i,
  input logic [NUM_OUT-1:0]       out_en_o,
  input logic [NUM_PLL-1:0]       pll_run_o,
  input logic                     osc_en_o,
  input logic                     fsel_o,
  input logic                     lock_err_o
);
  // R7: oscillator off means everything off
  p_osc_off_all_off_r7: assert property (@(posedge clk) disable iff (rst)
    !osc_en_o |-> (out_en_o == '0 && pll_run_o == '0));

  // R9: lock error is sticky
  p_lock_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    $past(lock_err_o) |-> lock_err_o);

  // R10: select level low outside frequency-select role
  p_fsel_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg_role_i) != 2'd0) |-> !fsel_o);

  // R6: a driven output never sits on a stopped PLL
  for (genvar o = 0; o < NUM_OUT; o++) begin : g_o
    for (genvar p = 0; p < NUM_PLL; p++) begin : g_p
      p_route_live_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(cfg_src_i[o*SRC_W +: SRC_W]) == SRC_W'(p + 1) && out_en_o[o]) |-> pll_run_o[p]);
    end
  end
endmodule

bind cim_ctrl_pin_mgr cim_ctrl_pin_mgr_chk #(
  .NUM_PLL(NUM_PLL), .NUM_OUT(NUM_OUT), .SRC_W(SRC_W)
) u_chk (
  .clk(clk), .rst(rst), .cfg_role_i(cfg_role_i), .cfg_src_i(cfg_src_i),
  .out_en_o(out_en_o), .pll_run_o(pll_run_o), .osc_en_o(osc_en_o),
  .fsel_o(fsel_o), .lock_err_o(lock_err_o)
);

// File: tb/cim_ctrl_pin_mgr_bench.sv
module cim_ctrl_pin_mgr_bench;
  localparam int NP = 3;
  localparam int NO = 3;
  localparam int SW = 2;
  localparam int LW = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pin = 1'b1;
  logic [1:0] role = 2'd0;
  logic [NP-1:0] pmask = '0;
  logic [NO-1:0] omask = '0;
  logic [NO*SW-1:0] src = {2'd1, 2'd2, 2'd1};
  logic [NP-1:0] lock = '1;
  logic [NO-1:0] out_en;
  logic [NP-1:0] run;
  logic osc, fsel, cerr, lerr;

  always #4 clk = ~clk;

  cim_ctrl_pin_mgr #(.NUM_PLL(NP), .NUM_OUT(NO), .LOCK_WAIT(LW)) u_cim_ctrl_pin_mgr (
    .clk(clk), .rst(rst), .pin_i(pin), .cfg_role_i(role), .cfg_pll_mask_i(pmask),
    .cfg_out_mask_i(omask), .cfg_src_i(src), .pll_lock_i(lock),
    .out_en_o(out_en), .pll_run_o(run), .osc_en_o(osc), .fsel_o(fsel),
    .cfg_err_o(cerr), .lock_err_o(lerr)
  );

  typedef struct {
    string         tag;
    logic [NO-1:0] out;
    logic [NP-1:0] run;
    logic          osc;
    logic          fsel;
    logic          cerr;
    logic          lerr;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic expect_st(input string tag, input logic [NO-1:0] o, input logic [NP-1:0] r,
                           input logic os, input logic fs, input logic ce, input logic le);
    exp_t e;
    e.tag = tag; e.out = o; e.run = r; e.osc = os; e.fsel = fs; e.cerr = ce; e.lerr = le;
    exp_q.push_back(e);
    @(negedge clk);
    #1;
  endtask

  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (out_en !== e.out || run !== e.run || osc !== e.osc || fsel !== e.fsel ||
          cerr !== e.cerr || lerr !== e.lerr) begin
        errors++;
        $display("FAIL %s: got out=%b run=%b osc=%b fsel=%b cerr=%b lerr=%b exp out=%b run=%b osc=%b fsel=%b cerr=%b lerr=%b",
                 e.tag, out_en, run, osc, fsel, cerr, lerr, e.out, e.run, e.osc, e.fsel, e.cerr, e.lerr);
      end
    end
  end

  initial begin
    cyc(3);
    expect_st("R11 reset", 3'b111, 3'b111, 1, 0, 0, 0);
    rst = 1'b0;
    cyc(8);
    expect_st("R1 fsel high", 3'b111, 3'b111, 1, 1, 0, 0);
    pin = 1'b0; cyc(8);
    expect_st("R1 fsel low", 3'b111, 3'b111, 1, 0, 0, 0);
    pin = 1'b1; cyc(6);
    expect_st("R2 latency", 3'b111, 3'b111, 1, 1, 0, 0);
    pin = 1'b0; cyc(8);
    pin = 1'b1; cyc(1); pin = 1'b0;
    cyc(3);
    expect_st("R3 pulse mid", 3'b111, 3'b111, 1, 0, 0, 0);
    cyc(5);
    expect_st("R3 pulse end", 3'b111, 3'b111, 1, 0, 0, 0);

    role = 2'd2; pin = 1'b1; cyc(8);
    expect_st("R12 oe high", 3'b111, 3'b111, 1, 0, 0, 0);
    pin = 1'b0; cyc(8);
    expect_st("R4 oe low", 3'b000, 3'b111, 1, 0, 0, 0);

    role = 2'd1; pmask = 3'b001; omask = 3'b101; cyc(8);
    expect_st("R5 suspend", 3'b010, 3'b110, 1, 0, 0, 0);
    omask = 3'b000; cyc(4);
    expect_st("R6 forced", 3'b010, 3'b110, 1, 0, 1, 0);
    pmask = 3'b000; omask = 3'b010; cyc(4);
    expect_st("R5 out only", 3'b101, 3'b111, 1, 0, 0, 0);
    src = {2'd1, 2'd0, 2'd1}; pmask = 3'b010; omask = 3'b000; cyc(4);
    expect_st("R6 ref source", 3'b111, 3'b101, 1, 0, 0, 0);
    pin = 1'b1; cyc(8);
    expect_st("R12 susp high", 3'b111, 3'b111, 1, 0, 0, 0);
    pmask = '0; src = {2'd1, 2'd2, 2'd1};

    role = 2'd3; lock = '0; pin = 1'b0; cyc(8);
    expect_st("R7 shutdown", 3'b000, 3'b000, 0, 0, 0, 0);
    pin = 1'b1; cyc(10);
    expect_st("R8 relock wait", 3'b000, 3'b111, 1, 0, 0, 0);
    lock = '1; cyc(6);
    expect_st("R8 relocked", 3'b111, 3'b111, 1, 0, 0, 0);

    lock = '0; pin = 1'b0; cyc(8);
    expect_st("R7 shutdown again", 3'b000, 3'b000, 0, 0, 0, 0);
    pin = 1'b1; cyc(10);
    expect_st("R9 before expiry", 3'b000, 3'b111, 1, 0, 0, 0);
    cyc(30);
    expect_st("R9 expired", 3'b111, 3'b111, 1, 0, 0, 1);

    lock = '1; role = 2'd0; cyc(8);
    expect_st("R1 back to fsel", 3'b111, 3'b111, 1, 1, 0, 1);
    role = 2'd2; cyc(4);
    expect_st("R10 fsel quiet", 3'b111, 3'b111, 1, 0, 0, 1);
    cyc(4);
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hung run exp completion");
    end
    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule